// File: doc/BRIEF.md
# Phase-Interleaved Video Memory Controller

This block lets a host CPU and a video display generator share one 8 kB video RAM without wait states. It divides the fast system clock into the two halves of a CPU bus clock (`phi2`) that it generates itself. The display side owns the RAM while `phi2` is low and the CPU owns it while `phi2` is high. The RAM array and the display timing generator are outside the block. The block drives the RAM's address, select, read enable, write enable and data direction, and it holds the display mode bits.

When `vid_en` is high, CPU addresses 0x6000 to 0x7FFF belong to the block. The lower 6 kB, 0x6000 to 0x77FF, map to RAM through CPU address bits 12..0. The upper 2 kB, 0x7800 to 0x7FFF, all alias one 8-bit mode register. The register drives `mode_bits` directly and reads back its stored value. When `vid_en` is low, the block stays off the CPU bus and selects nothing in the CPU phase.

The display side is a request/response stream. A fetch address is accepted only when `disp_valid` and `disp_ready` are both high. `disp_ready` is high only on the first clock of each low phase. A requester whose `disp_valid` is not high on that clock waits a full bus cycle for the next slot, so it must hold `disp_valid` and `disp_addr` until the handshake. The response has no back-pressure. `disp_rdata` is valid while `disp_rsp_valid` is high, and both stay unchanged for two phases (`2*HALF` clocks). The consumer must take the data within that window.

Top module: `vidmem_arbiter`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `phi2` is 0, `mode_bits` is 0x00, `disp_rsp_valid` is 0 and `ram_cs` is 0.
- R2: `phi2` toggles every `HALF` (default 4) clocks, starting low. A display fetch in a low phase reads RAM before a CPU write in the following high phase, so it returns the old byte and the next fetch returns the new one.
- R3: With `vid_en` high, `phi2` high and the CPU address in 0x6000..0x77FF, `ram_cs` is 1 and `ram_addr` equals CPU address bits 12..0. A read (`cpu_rw`=1) sets `ram_oe` and `cpu_rdata_oe` and returns the RAM byte on `cpu_rdata`. A write (`cpu_rw`=0) stores `cpu_wdata` in RAM.
- R4: With `vid_en` high, any CPU address in 0x7800..0x7FFF reaches the mode register and leaves `ram_cs` at 0. A write is stored at the end of the high phase and appears on `mode_bits`. A read returns the stored byte on `cpu_rdata`.
- R5: `ram_we` is 1 only during a CPU RAM write in the high phase, from its second clock through its next-to-last clock. `ram_we` is 0 on the first and last clocks of the phase, and `ram_addr` does not change while it is asserted.
- R6: With `vid_en` low, or with the CPU address outside 0x6000..0x7FFF, the high phase asserts neither `ram_cs`, `ram_we`, `ram_wdata_oe` nor `cpu_rdata_oe`. Writes change neither RAM nor the mode register.
- R7: `disp_ready` is 1 only on the first clock of the low phase. After a handshake, the rest of that low phase drives `ram_addr` with the accepted address, sets `ram_cs` and `ram_oe`, and keeps `ram_we` and `ram_wdata_oe` at 0. A low phase with no handshake leaves `ram_cs` at 0.
- R8: The RAM byte is captured on the last clock edge of the low phase. `disp_rsp_valid` and `disp_rdata` then stay unchanged until the end of the next low phase. At that edge, `disp_rsp_valid` falls if no fetch was accepted in that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each bus phase lasts HALF clocks |
| rst | input | 1 | Synchronous reset, active high |
| vid_en | input | 1 | Maps the video window into CPU space when high |
| phi2 | output | 1 | Generated bus clock: low = display phase, high = CPU phase |
| cpu_addr | input | 16 | CPU address, held stable through the high phase |
| cpu_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data toward the CPU |
| cpu_rdata_oe | output | 1 | Block drives the CPU data bus |
| disp_valid | input | 1 | Display fetch request valid |
| disp_ready | output | 1 | Fetch slot open (first clock of low phase) |
| disp_addr | input | 13 | Display fetch address |
| disp_rsp_valid | output | 1 | Held display read data valid |
| disp_rdata | output | 8 | Held display read data |
| ram_addr | output | 13 | RAM address |
| ram_cs | output | 1 | RAM chip select, active high |
| ram_oe | output | 1 | RAM output enable, active high |
| ram_we | output | 1 | RAM write enable, active high |
| ram_wdata | output | 8 | Data toward the RAM |
| ram_wdata_oe | output | 1 | Data direction: block drives the RAM data bus |
| ram_rdata | input | 8 | Data from the RAM |
| mode_bits | output | 8 | Mode register contents for the display generator |

## Verification
The CPU-side selects, read data and output enables are combinational from the phase state and the CPU inputs. They are due on the same clock they belong to. `ram_we` is due only on the second through next-to-last clocks of the high phase. A mode write appears on `mode_bits` on the first clock of the following low phase. The display response is due on the first clock of the high phase after the handshake. It must then hold through the following low phase. Every bench operation starts on the first clock of a low phase and counts whole clocks from there. It samples each result on the falling edge in the exact slot where it is due: phase clock 1 for the low-phase RAM controls, clocks 0, 1 and 3 of the high phase for the write enable, and clocks 0 and 3 for response stability.

// File: rtl/vidmem_pkg.sv
package vidmem_pkg;

  // Per-phase CPU-side control decoded from address, direction and phase
  typedef struct packed {
    logic ram_sel;   // RAM selected in CPU phase
    logic reg_sel;   // mode register selected in CPU phase
    logic ram_oe;    // RAM read in CPU phase
    logic ram_we;    // RAM write strobe (already windowed)
    logic wdata_oe;  // block drives RAM data pins
    logic rdata_oe;  // block drives CPU data bus
    logic reg_wr;    // mode register write pending this phase
  } cpu_ctl_t;

  function automatic logic in_span(input logic [15:0] a,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/vm_phase_seq.sv
module vm_phase_seq #(
  parameter int HALF = 4,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic phi2,
  output logic low_first,
  output logic low_last,
  output logic high_last,
  output logic we_window
);

  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      phi2 <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      phi2 <= ~phi2;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign low_first = !phi2 && (cnt == '0);
  assign low_last  = !phi2 && (cnt == LAST);
  assign high_last =  phi2 && (cnt == LAST);
  assign we_window =  phi2 && (cnt != '0) && (cnt != LAST);

  // R2: the phase changes only after a full HALF-clock count
  assert_phase_len_R2: assert property (@(posedge clk) disable iff (rst)
    (phi2 != $past(phi2)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/vm_cpu_decode.sv
module vm_cpu_decode
  import vidmem_pkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h6000,
  parameter logic [15:0] REG_BASE = 16'h7800,
  parameter logic [15:0] WIN_LAST = 16'h7FFF
) (
  input  logic        vid_en,
  input  logic        phi2,
  input  logic        we_window,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rw,
  output cpu_ctl_t    ctl
);

  logic in_win, hit_reg, hit_ram;

  always_comb begin
    in_win  = vid_en && in_span(cpu_addr, WIN_BASE, WIN_LAST);
    hit_reg = in_win && (cpu_addr >= REG_BASE);
    hit_ram = in_win && !hit_reg;

    ctl.ram_sel  = phi2 && hit_ram;
    ctl.reg_sel  = phi2 && hit_reg;
    ctl.ram_oe   = ctl.ram_sel && cpu_rw;
    ctl.wdata_oe = ctl.ram_sel && !cpu_rw;
    ctl.ram_we   = ctl.wdata_oe && we_window;
    ctl.rdata_oe = (ctl.ram_sel || ctl.reg_sel) && cpu_rw;
    ctl.reg_wr   = ctl.reg_sel && !cpu_rw;
  end

endmodule

// File: rtl/vm_disp_port.sv
module vm_disp_port #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic          low_first,
  input  logic          low_last,
  input  logic          disp_valid,
  output logic          disp_ready,
  input  logic [AW-1:0] disp_addr,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_active,
  input  logic [DW-1:0] ram_rdata,
  output logic          disp_rsp_valid,
  output logic [DW-1:0] disp_rdata
);

  assign disp_ready = low_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr     <= '0;
      fetch_active   <= 1'b0;
      disp_rsp_valid <= 1'b0;
      disp_rdata     <= '0;
    end else begin
      if (disp_ready && disp_valid) begin
        fetch_addr   <= disp_addr;
        fetch_active <= 1'b1;
      end
      if (low_last) begin
        fetch_active   <= 1'b0;
        disp_rsp_valid <= fetch_active;
        if (fetch_active) disp_rdata <= ram_rdata;
      end
    end
  end

  // R7: the fetch slot is offered only in the display phase
  assert_ready_low_only_R7: assert property (@(posedge clk) disable iff (rst)
    disp_ready |-> !phi2);

  // R7: a fetch never spills into the CPU phase
  assert_fetch_low_only_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_active |-> !phi2);

  // R8: held response changes only at a capture edge
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(low_last) |-> ($stable(disp_rdata) && $stable(disp_rsp_valid)));

endmodule

// File: rtl/vm_mode_reg.sv
module vm_mode_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode
);

  always_ff @(posedge clk) begin
    if (rst)        mode <= '0;
    else if (wr_en) mode <= wdata;
  end

  // R4: mode bits move only after a register write
  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(mode));

endmodule

// File: rtl/vidmem_arbiter.sv
module vidmem_arbiter
  import vidmem_pkg::*;
#(
  parameter int          HALF     = 4,
  parameter int          AW       = 13,
  parameter int          DW       = 8,
  parameter logic [15:0] WIN_BASE = 16'h6000,
  parameter logic [15:0] REG_BASE = 16'h7800,
  parameter logic [15:0] WIN_LAST = 16'h7FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vid_en,
  output logic          phi2,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rw,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_oe,
  input  logic          disp_valid,
  output logic          disp_ready,
  input  logic [AW-1:0] disp_addr,
  output logic          disp_rsp_valid,
  output logic [DW-1:0] disp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs,
  output logic          ram_oe,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_wdata_oe,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] mode_bits
);

  logic          low_first, low_last, high_last, we_window;
  logic [AW-1:0] fetch_addr;
  logic          fetch_active;
  cpu_ctl_t      ctl;

  vm_phase_seq #(.HALF(HALF)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .low_first (low_first),
    .low_last  (low_last),
    .high_last (high_last),
    .we_window (we_window)
  );

  vm_cpu_decode #(
    .WIN_BASE (WIN_BASE),
    .REG_BASE (REG_BASE),
    .WIN_LAST (WIN_LAST)
  ) u_dec (
    .vid_en    (vid_en),
    .phi2      (phi2),
    .we_window (we_window),
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .ctl       (ctl)
  );

  vm_disp_port #(.AW(AW), .DW(DW)) u_disp (
    .clk            (clk),
    .rst            (rst),
    .phi2           (phi2),
    .low_first      (low_first),
    .low_last       (low_last),
    .disp_valid     (disp_valid),
    .disp_ready     (disp_ready),
    .disp_addr      (disp_addr),
    .fetch_addr     (fetch_addr),
    .fetch_active   (fetch_active),
    .ram_rdata      (ram_rdata),
    .disp_rsp_valid (disp_rsp_valid),
    .disp_rdata     (disp_rdata)
  );

  vm_mode_reg #(.DW(DW)) u_mode (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ctl.reg_wr && high_last),
    .wdata (cpu_wdata),
    .mode  (mode_bits)
  );

  // Phase-steered RAM port: display owns low phase, CPU owns high phase
  always_comb begin
    if (phi2) begin
      ram_addr = cpu_addr[AW-1:0];
      ram_cs   = ctl.ram_sel;
      ram_oe   = ctl.ram_oe;
    end else begin
      ram_addr = fetch_addr;
      ram_cs   = fetch_active;
      ram_oe   = fetch_active;
    end
  end

  assign ram_we       = ctl.ram_we;
  assign ram_wdata    = cpu_wdata;
  assign ram_wdata_oe = ctl.wdata_oe;
  assign cpu_rdata_oe = ctl.rdata_oe;
  assign cpu_rdata    = !ctl.rdata_oe ? '0 : (ctl.reg_sel ? mode_bits : ram_rdata);

  // R5: write strobe confined to the CPU phase
  assert_we_high_only_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> phi2);

  // R5: strobe already low on the clock before phi2 falls
  assert_we_off_before_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!phi2 && $past(phi2)) |-> !$past(ram_we));

  // R5: address held while the strobe stays asserted
  assert_we_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> $stable(ram_addr));

  // R6: disabled window leaves RAM and CPU bus alone
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!vid_en && phi2) |-> (!ram_cs && !ram_we && !cpu_rdata_oe && !ram_wdata_oe));

  // R7: display phase never drives RAM data
  assert_low_readonly_R7: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> (!ram_wdata_oe && !ram_we));

  // R3: read and write enables never together
  assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, ram_oe}));

endmodule

// File: tb/vidmem_arbiter_tb.sv
`timescale 1ns/1ps
module vidmem_arbiter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vid_en = 1'b1;
  logic        phi2;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [12:0] disp_addr = 13'h0000;
  logic        disp_rsp_valid;
  logic [7:0]  disp_rdata;
  logic [12:0] ram_addr;
  logic        ram_cs, ram_oe, ram_we, ram_wdata_oe;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'h00;
  logic [7:0]  mode_bits;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  vidmem_arbiter u_dut (
    .clk(clk), .rst(rst), .vid_en(vid_en), .phi2(phi2),
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_addr(disp_addr),
    .disp_rsp_valid(disp_rsp_valid), .disp_rdata(disp_rdata),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_wdata_oe(ram_wdata_oe), .ram_rdata(ram_rdata),
    .mode_bits(mode_bits)
  );

  // RAM model: unwritten bytes hold a fixed address pattern
  logic [7:0] bmem [int];

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]};
  endfunction

  function automatic logic [7:0] rd(input logic [12:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return pat(a);
  endfunction

  always @(posedge clk) begin
    if (ram_cs && ram_we) bmem[int'(ram_addr)] = ram_wdata;
  end

  always @(posedge clk) begin
    #1;
    ram_rdata = rd(ram_addr);
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Samples of one bus cycle
  logic s_rdy0, s_rdy1, s_cs_lo, s_oe_lo, s_we_lo, s_wdoe_lo, s_rspv_lo;
  logic [12:0] s_raddr_lo, s_raddr_hi;
  logic s_phi_lo, s_phi_hi, s_we_hi0, s_we_hi1, s_we_hi3, s_cs_hi, s_oe_hi;
  logic s_rspv, s_rspv3;
  logic [7:0] s_rd_hi, s_rspd, s_rspd3, s_rspd_lo;

  // Starts and ends on the first clock of a low phase
  task automatic bus_cycle(input logic en, input logic rw, input logic [15:0] a,
                           input logic [7:0] wd, input logic dv, input logic [12:0] da);
    vid_en = en; cpu_rw = rw; cpu_addr = a; cpu_wdata = wd;
    disp_valid = dv; disp_addr = da;
    s_rdy0 = disp_ready; s_phi_lo = phi2;
    @(negedge clk);
    disp_valid = 1'b0;
    s_rdy1 = disp_ready; s_cs_lo = ram_cs; s_oe_lo = ram_oe; s_we_lo = ram_we;
    s_wdoe_lo = ram_wdata_oe; s_raddr_lo = ram_addr;
    s_rspv_lo = disp_rsp_valid; s_rspd_lo = disp_rdata;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    s_we_hi0 = ram_we; s_rspv = disp_rsp_valid; s_rspd = disp_rdata;
    @(negedge clk);
    s_phi_hi = phi2; s_cs_hi = ram_cs; s_we_hi1 = ram_we; s_oe_hi = cpu_rdata_oe;
    s_rd_hi = cpu_rdata; s_raddr_hi = ram_addr;
    @(negedge clk);
    @(negedge clk);
    s_we_hi3 = ram_we; s_rspv3 = disp_rsp_valid; s_rspd3 = disp_rdata;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic       en;
    logic       rw;
    logic [15:0] addr;
    logic [7:0] wd;
    logic       ecs;
    logic       ewe;
    logic       eoe;
    logic [7:0] erd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h6000, 8'hA5, 1'b1, 1'b1, 1'b0, 8'h00, 4'd3}, // R3 write low end
    '{1'b1, 1'b1, 16'h6000, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 4'd3}, // R3 read back
    '{1'b1, 1'b0, 16'h77FF, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h00, 4'd3}, // R3 last RAM byte
    '{1'b1, 1'b1, 16'h77FF, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3C, 4'd3}, // R3
    '{1'b1, 1'b1, 16'h6123, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22, 4'd3}, // R3 unwritten pattern
    '{1'b1, 1'b0, 16'h7800, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 register write
    '{1'b1, 1'b1, 16'h7FFF, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 4'd4}, // R4 alias read
    '{1'b0, 1'b1, 16'h6000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // R6 disabled read
    '{1'b0, 1'b0, 16'h6100, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // R6 disabled write
    '{1'b1, 1'b1, 16'h6100, 8'h00, 1'b1, 1'b0, 1'b1, 8'h01, 4'd6}, // R6 no store
    '{1'b1, 1'b1, 16'h5FFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // R6 below window
    '{1'b1, 1'b0, 16'h8000, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // R6 above window
    '{1'b0, 1'b0, 16'h7800, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6}, // R6 register guarded
    '{1'b1, 1'b1, 16'h7800, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 4'd4}, // R4 still 0x5A
    '{1'b1, 1'b1, 16'h6000, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 4'd6}  // R6 aliased addr kept
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phi2", int'(phi2), 0);
    chk("R1 mode_bits", int'(mode_bits), 0);
    chk("R1 rsp_valid", int'(disp_rsp_valid), 0);
    chk("R1 ram_cs", int'(ram_cs), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tg;
      bus_cycle(VECS[i].en, VECS[i].rw, VECS[i].addr, VECS[i].wd, 1'b0, 13'h0);
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (i == 0) begin
        chk("R2 phi2 low phase", int'(s_phi_lo), 0);
        chk("R2 phi2 high phase", int'(s_phi_hi), 1);
      end
      chk({tg, " cs"}, int'(s_cs_hi), int'(VECS[i].ecs));
      chk({tg, " we"}, int'(s_we_hi1), int'(VECS[i].ewe));
      chk({tg, " rdata_oe"}, int'(s_oe_hi), int'(VECS[i].eoe));
      if (VECS[i].eoe) chk({tg, " rdata"}, int'(s_rd_hi), int'(VECS[i].erd));
      if (VECS[i].ecs) chk({tg, " addr"}, int'(s_raddr_hi), int'(VECS[i].addr[12:0]));
      if (VECS[i].ewe) begin
        chk("R5 we first clock", int'(s_we_hi0), 0);
        chk("R5 we last clock", int'(s_we_hi3), 0);
      end
    end
    chk("R4 mode_bits", int'(mode_bits), 8'h5A);

    // Fetch 0x0200 while CPU writes 0x6200 in the same bus cycle
    bus_cycle(1'b1, 1'b0, 16'h6200, 8'h99, 1'b1, 13'h0200);
    chk("R7 ready first clock", int'(s_rdy0), 1);
    chk("R7 ready second clock", int'(s_rdy1), 0);
    chk("R7 cs low phase", int'(s_cs_lo), 1);
    chk("R7 oe low phase", int'(s_oe_lo), 1);
    chk("R7 addr low phase", int'(s_raddr_lo), 13'h0200);
    chk("R7 no write low phase", int'(s_we_lo | s_wdoe_lo), 0);
    chk("R8 rsp valid", int'(s_rspv), 1);
    chk("R2 fetch before write", int'(s_rspd), 8'h02);
    chk("R8 rsp stable", int'(s_rspd3), 8'h02);
    chk("R5 we second clock", int'(s_we_hi1), 1);
    chk("R5 we last clock", int'(s_we_hi3), 0);

    bus_cycle(1'b1, 1'b1, 16'h0000, 8'h00, 1'b1, 13'h0200);
    chk("R8 held into next low", int'(s_rspv_lo), 1);
    chk("R8 held data next low", int'(s_rspd_lo), 8'h02);
    chk("R2 fetch sees write", int'(s_rspd), 8'h99);
    chk("R6 outside window cs", int'(s_cs_hi), 0);

    bus_cycle(1'b1, 1'b1, 16'h0000, 8'h00, 1'b0, 13'h0000);
    chk("R7 idle low phase cs", int'(s_cs_lo), 0);
    chk("R8 held before drop", int'(s_rspv_lo), 1);
    chk("R8 rsp drops", int'(s_rspv), 0);

    bus_cycle(1'b1, 1'b1, 16'h0000, 8'h00, 1'b1, 13'h1FFF);
    chk("R7 top fetch addr", int'(s_raddr_lo), 13'h1FFF);
    chk("R8 top fetch data", int'(s_rspd), 8'hE0);

    finish_run();
  end

endmodule